// File: doc/BRIEF.md
# Flow-control pause frame detector

This block watches the bytes of a received Ethernet frame, starting with the first byte after the start-of-frame delimiter. It decides whether the frame is a MAC control PAUSE request. It checks the destination address, the length/type field and the control opcode while the bytes stream past. It also stores the two 16-bit parameters that follow the opcode: the pause time and the extended pause time.

The decision is made on the last byte of the frame. A frame counts only if three things hold: every header byte matched, the frame was long enough to carry both parameters, and the upstream CRC checker reports a good checksum on that last byte. When all three hold, the block raises a one-cycle strobe. At the same time it updates two parameter outputs, which keep their values until the next accepted frame. The block does not compute the CRC, and it does not drop or forward frames.

Top module: `pause_frame_detect`

## Requirements
- R1: After reset, `pause_valid` is 0 and both `pause_time` and `pause_ext` are 0.
- R2: A frame is accepted when all of the following hold: byte indices 0..5 are 01 80 C2 00 00 01, indices 12..13 are 88 08, and indices 14..15 are 00 01. For an accepted frame, `pause_valid` is high for exactly one cycle, in the cycle after the end-of-frame beat, and only when `in_crc_ok` is high on that beat.
- R3: `pause_time` is made from bytes 16 (high) and 17 (low). `pause_ext` is made from bytes 18 (high) and 19 (low). Both become visible together with the strobe.
- R4: A frame whose end-of-frame beat has `in_crc_ok` low raises no strobe.
- R5: A frame with any destination address byte different from the expected address raises no strobe.
- R6: A frame whose length/type field is not 0x8808 raises no strobe.
- R7: A frame whose opcode is not 0x0001 raises no strobe.
- R8: A frame that ends before byte index 19 has been received raises no strobe, even when its header and CRC are good.
- R9: A start-of-frame beat restarts byte counting and header matching, even inside an unfinished frame. A good frame that follows is accepted.
- R10: Cycles with `in_valid` low do not advance the parse. A frame sent with idle gaps between its bytes is accepted and gives the same parameters.
- R11: `pause_time` and `pause_ext` change only in a cycle where `pause_valid` is high. They keep their values through frames that are rejected.
- R12: Beats outside a frame are ignored. This covers any valid beat after an end-of-frame beat and before the next start-of-frame beat, and it includes an end-of-frame beat with a good CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | This byte is frame byte index 0 |
| in_eof | input | 1 | This byte is the last byte of the frame |
| in_data | input | 8 | Frame byte |
| in_crc_ok | input | 1 | CRC result; read only on the end-of-frame beat |
| pause_valid | output | 1 | One-cycle strobe for an accepted pause frame |
| pause_time | output | 16 | Pause time from the last accepted frame |
| pause_ext | output | 16 | Extended pause time from the last accepted frame |

## Verification
The bench builds the block with its default parameters. With a 7-bit byte counter, full 64-byte frames fit below the saturation point, so a long frame can be checked against a short one that stops at byte 19. With address matching switched on, a corrupted destination byte can be shown to be rejected. The address-free variant is not built in this bench.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   localparam int TYPE_HI_IDX  = 12;
   localparam int TYPE_LO_IDX  = 13;
   localparam int OPC_HI_IDX   = 14;
   localparam int OPC_LO_IDX   = 15;
   localparam int PARAM_IDX    = 16;
   localparam int PARAM_BYTES  = 4;
   localparam int LAST_NEEDED  = PARAM_IDX + PARAM_BYTES - 1;
   localparam int ADDR_BYTES   = 6;
   typedef logic [7:0] octet_t;
endpackage

// File: rtl/pfd_byte_counter.sv
module pfd_byte_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   output logic             beat,
   output logic [CNT_W-1:0] idx
);
   localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             in_frame_q;

   generate
      if (CNT_W < 5) begin : g_bad_width
         $error("pfd_byte_counter: CNT_W must reach byte index 19");
      end
   endgenerate

   assign beat = in_valid & (in_sof | in_frame_q);
   assign idx  = in_sof ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
      end else if (beat) begin
         cnt_q      <= (idx == IDX_MAX) ? IDX_MAX : idx + 1'b1;
         in_frame_q <= ~in_eof;
      end
   end

   // R9
   sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/pfd_header_match.sv
module pfd_header_match
   import pfd_pkg::*;
#(
   parameter int          CNT_W    = 7,
   parameter bit          MATCH_DA = 1'b1,
   parameter logic [47:0] DEST     = 48'h0180C2000001,
   parameter logic [15:0] ETYPE    = 16'h8808,
   parameter logic [15:0] OPCODE   = 16'h0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             in_sof,
   input  logic [CNT_W-1:0] idx,
   input  octet_t           in_data,
   output logic             hdr_ok_d
);
   logic   hdr_ok_q;
   logic   da_care, care;
   octet_t da_exp, exp_byte;
   logic [47:0] da_shift;

   assign da_shift = DEST << {idx[2:0], 3'b000};

   generate
      if (MATCH_DA) begin : g_da_on
         assign da_care = (idx < CNT_W'(ADDR_BYTES));
         assign da_exp  = da_shift[47:40];
      end else begin : g_da_off
         assign da_care = 1'b0;
         assign da_exp  = '0;
      end
   endgenerate

   always_comb begin
      care     = da_care;
      exp_byte = da_exp;
      if (idx == CNT_W'(TYPE_HI_IDX)) begin
         care = 1'b1; exp_byte = ETYPE[15:8];
      end else if (idx == CNT_W'(TYPE_LO_IDX)) begin
         care = 1'b1; exp_byte = ETYPE[7:0];
      end else if (idx == CNT_W'(OPC_HI_IDX)) begin
         care = 1'b1; exp_byte = OPCODE[15:8];
      end else if (idx == CNT_W'(OPC_LO_IDX)) begin
         care = 1'b1; exp_byte = OPCODE[7:0];
      end
   end

   always_comb begin
      hdr_ok_d = hdr_ok_q;
      if (beat)
         hdr_ok_d = (in_sof | hdr_ok_q) & (~care | (in_data == exp_byte));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hdr_ok_q <= 1'b0;
      else        hdr_ok_q <= hdr_ok_d;
   end

   // R5 R6 R7
   hdr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && care && (in_data != exp_byte)) |=> !hdr_ok_q);
endmodule

// File: rtl/pfd_param_capture.sv
module pfd_param_capture
   import pfd_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic [CNT_W-1:0] idx,
   input  octet_t           in_data,
   output logic [15:0]      time_d,
   output logic [15:0]      ext_d
);
   octet_t slot_d [PARAM_BYTES];

   generate
      for (genvar g = 0; g < PARAM_BYTES; g++) begin : g_slot
         octet_t slot_q;
         logic   hit;
         assign hit        = beat & (idx == CNT_W'(PARAM_IDX + g));
         assign slot_d[g]  = hit ? in_data : slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d[g];
         end
      end
   endgenerate

   assign time_d = {slot_d[0], slot_d[1]};
   assign ext_d  = {slot_d[2], slot_d[3]};
endmodule

// File: rtl/pause_frame_detect.sv
module pause_frame_detect
   import pfd_pkg::*;
#(
   parameter int          CNT_W    = 7,
   parameter bit          MATCH_DA = 1'b1,
   parameter logic [47:0] DEST     = 48'h0180C2000001,
   parameter logic [15:0] ETYPE    = 16'h8808,
   parameter logic [15:0] OPCODE   = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_sof,
   input  logic        in_eof,
   input  logic [7:0]  in_data,
   input  logic        in_crc_ok,
   output logic        pause_valid,
   output logic [15:0] pause_time,
   output logic [15:0] pause_ext
);
   logic             beat, hdr_ok_d, accept;
   logic [CNT_W-1:0] idx;
   logic [15:0]      time_d, ext_d;

   pfd_byte_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .beat(beat), .idx(idx));

   pfd_header_match #(.CNT_W(CNT_W), .MATCH_DA(MATCH_DA), .DEST(DEST),
                      .ETYPE(ETYPE), .OPCODE(OPCODE)) u_hdr (
      .clk(clk), .rst_n(rst_n), .beat(beat), .in_sof(in_sof), .idx(idx),
      .in_data(in_data), .hdr_ok_d(hdr_ok_d));

   pfd_param_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .beat(beat), .idx(idx), .in_data(in_data),
      .time_d(time_d), .ext_d(ext_d));

   assign accept = beat & in_eof & in_crc_ok & hdr_ok_d &
                   (idx >= CNT_W'(LAST_NEEDED));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pause_valid <= 1'b0;
         pause_time  <= '0;
         pause_ext   <= '0;
      end else begin
         pause_valid <= accept;
         if (accept) begin
            pause_time <= time_d;
            pause_ext  <= ext_d;
         end
      end
   end

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause_valid |=> !pause_valid);
   // R4
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause_valid |-> $past(in_valid && in_eof && in_crc_ok));
   // R11
   param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_valid |-> ($stable(pause_time) && $stable(pause_ext)));
endmodule

// File: tb/pause_frame_detect_tb.sv
module pause_frame_detect_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_crc_ok = 1'b0;
   logic [7:0]  in_data = '0;
   logic        pause_valid;
   logic [15:0] pause_time, pause_ext;

   int checks = 0, errors = 0, strobes = 0;
   logic [7:0] fr [64];

   always #5 clk = ~clk;

   pause_frame_detect u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .in_crc_ok(in_crc_ok),
      .pause_valid(pause_valid), .pause_time(pause_time), .pause_ext(pause_ext));

   always @(negedge clk) if (rst_n && pause_valid) strobes++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic build(input bit da_bad, input logic [15:0] ty, input logic [15:0] op,
                        input logic [15:0] pt, input logic [15:0] pe);
      logic [47:0] da = 48'h0180C2000001;
      for (int i = 0; i < 64; i++) fr[i] = 8'h00;
      for (int i = 0; i < 6; i++) fr[i] = da[47-8*i -: 8];
      if (da_bad) fr[4] = 8'h5A;
      for (int i = 6; i < 12; i++) fr[i] = 8'(8'h10 + i);
      fr[12] = ty[15:8]; fr[13] = ty[7:0];
      fr[14] = op[15:8]; fr[15] = op[7:0];
      fr[16] = pt[15:8]; fr[17] = pt[7:0];
      fr[18] = pe[15:8]; fr[19] = pe[7:0];
      for (int i = 60; i < 64; i++) fr[i] = 8'hA5;
   endtask

   task automatic beat(input logic [7:0] d, input bit s, input bit e, input bit c);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_crc_ok = c;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_ok = 1'b0; in_data = '0;
   endtask

   // Sends fr[0..len-1]; checks strobe timing, count and parameters.
   task automatic send(input int len, input bit crc, input int gap, input bit exp_ok,
                       input logic [15:0] exp_pt, input logic [15:0] exp_pe,
                       input string req);
      int s0 = strobes;
      for (int i = 0; i < len; i++) begin
         beat(fr[i], i == 0, i == len - 1, crc && (i == len - 1));
         if (i != len - 1) for (int g = 0; g < gap; g++) idle();
      end
      idle();
      chk(pause_valid == exp_ok, req, pause_valid, exp_ok);
      chk(pause_time == exp_pt, req, pause_time, exp_pt);
      chk(pause_ext == exp_pe, req, pause_ext, exp_pe);
      idle();
      chk(pause_valid == 1'b0, req, pause_valid, 0);
      chk(strobes - s0 == int'(exp_ok), req, strobes - s0, exp_ok);
   endtask

   task automatic t_reset();
      chk(pause_valid == 1'b0, "R1", pause_valid, 0);
      chk(pause_time == 16'h0 && pause_ext == 16'h0, "R1", pause_time, 0);
   endtask

   task automatic t_good();
      build(0, 16'h8808, 16'h0001, 16'hBEEF, 16'h1234);
      send(64, 1, 0, 1, 16'hBEEF, 16'h1234, "R2 R3");
   endtask

   task automatic t_bad_crc();
      build(0, 16'h8808, 16'h0001, 16'h7777, 16'h8888);
      send(64, 0, 0, 0, 16'hBEEF, 16'h1234, "R4 R11");
   endtask

   task automatic t_bad_da();
      build(1, 16'h8808, 16'h0001, 16'h1111, 16'h2222);
      send(64, 1, 0, 0, 16'hBEEF, 16'h1234, "R5");
   endtask

   task automatic t_bad_type();
      build(0, 16'h0800, 16'h0001, 16'h1111, 16'h2222);
      send(64, 1, 0, 0, 16'hBEEF, 16'h1234, "R6");
   endtask

   task automatic t_bad_opc();
      build(0, 16'h8808, 16'h0101, 16'h1111, 16'h2222);
      send(64, 1, 0, 0, 16'hBEEF, 16'h1234, "R7");
   endtask

   task automatic t_short();
      build(0, 16'h8808, 16'h0001, 16'h3333, 16'h4444);
      send(19, 1, 0, 0, 16'hBEEF, 16'h1234, "R8");
      send(20, 1, 0, 1, 16'h3333, 16'h4444, "R8 boundary");
   endtask

   task automatic t_restart();
      build(0, 16'h8808, 16'h0001, 16'h0A0B, 16'h0C0D);
      for (int i = 0; i < 15; i++) beat(8'hEE, i == 0, 0, 0);
      send(64, 1, 0, 1, 16'h0A0B, 16'h0C0D, "R9");
   endtask

   task automatic t_gaps();
      build(0, 16'h8808, 16'h0001, 16'hF00D, 16'h00FF);
      send(64, 1, 2, 1, 16'hF00D, 16'h00FF, "R10");
   endtask

   task automatic t_outside();
      int s0 = strobes;
      for (int i = 0; i < 24; i++) beat(fr[i], 0, i == 23, i == 23);
      idle(); idle();
      chk(strobes == s0, "R12", strobes - s0, 0);
      chk(pause_time == 16'hF00D, "R12", pause_time, 16'hF00D);
      build(0, 16'h8808, 16'h0001, 16'h0000, 16'hFFFF);
      send(64, 1, 0, 1, 16'h0000, 16'hFFFF, "R12 recovery");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_bad_crc();
      t_bad_da();
      t_bad_type();
      t_bad_opc();
      t_short();
      t_restart();
      t_gaps();
      t_outside();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule